// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block collects interrupt sources for a DMA engine into two groups: ordinary events and error events. Each group has a sticky status word and a mask word. The DMA logic raises single-cycle event pulses, one bit per source. Each pulse sets the matching status bit, and the bit stays set until software clears it.

Software reaches the bank through a single-cycle register bus, made of a valid, a write flag, a word address and a data word. Read data is combinational from the address. A status bit is cleared by writing a one to it. A mask word cannot be written directly. Software unmasks sources by writing ones to an enable register and masks them by writing ones to a disable register. One registered, level-sensitive interrupt line is raised while any unmasked status bit is set in either group.

Top module: `irq_regbank`

## Requirements
- R1: After reset both status words read 0x00000000, the normal mask (0x008) reads 0x07FFFFFF, the error mask (0x018) reads 0xFFFFFFFF and `irq_o` is low.
- R2: A 1 on a bit of `evt_nrm_i` or `evt_err_i` in one cycle sets that bit of the normal status (0x004) or error status (0x014), and the bit stays set afterwards.
- R3: A write to a status word (0x004 or 0x014) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to an enable register (0x00C normal, 0x01C error) clears the mask bits written as 1. The enable register reads as 0.
- R5: A write to a disable register (0x010 normal, 0x020 error) sets the mask bits written as 1. The disable register reads as 0.
- R6: A direct write to a mask word (0x008 or 0x018) leaves that mask unchanged.
- R7: `irq_o` is high when, in either group, any bit of status AND NOT mask is set. It is registered, so it follows a status or mask change one cycle later.
- R8: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: An address outside 0x004..0x020 reads as 0, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_nrm_i | input | 32 | Normal event pulses, one bit per source |
| evt_err_i | input | 32 | Error event pulses, one bit per source |
| bus_valid_i | input | 1 | Bus access valid this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of a 32-bit word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The hardest case to create from the ports is an event pulse landing on a status bit in the same clock edge as a software write-one-to-clear of that bit. The stimulus drives the error event bit and the clearing bus write inside one cycle. The same write also clears a second bit that has no competing event. The check is that only the contested bit survives.

A second hard case is bits 27 to 31 of the normal group, which are unmasked at reset. The stimulus pulses one of them before any enable write, to show that the line rises with no software setup.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  localparam int unsigned NGRP = 2;
  localparam int unsigned GRP_BASE = 32'h004;
  localparam int unsigned GRP_SPAN = 32'h010;

  typedef enum logic [1:0] {
    SLOT_STAT = 2'd0,
    SLOT_MASK = 2'd1,
    SLOT_EN   = 2'd2,
    SLOT_DIS  = 2'd3
  } slot_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_GRP  = NGRP,
  localparam int unsigned GIDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [GIDX_W-1:0] grp_o,
  output slot_e             slot_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(GRP_BASE);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(N_GRP * GRP_SPAN);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off    = addr_i - BASE;
    hit_o  = (addr_i >= BASE) && (off < SPAN);
    grp_o  = off[GIDX_W+3:4];
    slot_o = slot_e'(off[3:2]);
  end
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned        DATA_W   = 32,
  parameter logic [DATA_W-1:0]  RST_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              stat_wr_i,
  input  logic              en_wr_i,
  input  logic              dis_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] stat_q, stat_d, mask_q, mask_d;
  logic [DATA_W-1:0] clr_vec, en_vec, dis_vec;
  logic              stat_ce, mask_ce;

  always_comb begin
    clr_vec = stat_wr_i ? wdata_i : '0;
    en_vec  = en_wr_i   ? wdata_i : '0;
    dis_vec = dis_wr_i  ? wdata_i : '0;
    stat_d  = (stat_q & ~clr_vec) | evt_i;
    stat_ce = stat_wr_i | (|evt_i);
    mask_d  = (mask_q & ~en_vec) | dis_vec;
    mask_ce = en_wr_i | dis_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= RST_MASK;
    end else begin
      if (stat_ce) stat_q <= stat_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);

  // R2: a set bit that was not cleared stays set
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));

  // R3: a cleared bit with no competing event reads zero
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_vec) & ~$past(evt_i) & stat_q) == '0));

  // R8: an event always lands, even against a clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_i) & ~stat_q) == '0));

  a_r4_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> ((mask_q & $past(wdata_i)) == '0));

  a_r5_disable: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr_i |=> ((~mask_q & $past(wdata_i)) == '0));

  // R6: only the enable and disable paths move the mask
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_wr_i || dis_wr_i) |=> $stable(mask_q));
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       ADDR_W       = 12,
  parameter logic [DATA_W-1:0] NRM_RST_MASK = 32'h07FF_FFFF,
  parameter logic [DATA_W-1:0] ERR_RST_MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_nrm_i,
  input  logic [DATA_W-1:0] evt_err_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned GIDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic              rst_s_n;
  logic              dec_hit;
  logic [GIDX_W-1:0] dec_grp;
  slot_e             dec_slot;
  logic              wr_acc;
  logic [DATA_W-1:0] evt_a  [NGRP];
  logic [DATA_W-1:0] stat_a [NGRP];
  logic [DATA_W-1:0] mask_a [NGRP];
  logic [NGRP-1:0]   pend_a;
  logic              irq_q, irq_d;

  irq_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  irq_addr_dec #(.ADDR_W(ADDR_W), .N_GRP(NGRP)) i_dec (
    .addr_i (bus_addr_i),
    .hit_o  (dec_hit),
    .grp_o  (dec_grp),
    .slot_o (dec_slot)
  );

  assign wr_acc   = bus_valid_i & bus_write_i & dec_hit;
  assign evt_a[0] = evt_nrm_i;
  assign evt_a[1] = evt_err_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [DATA_W-1:0] RM = (g == 0) ? NRM_RST_MASK : ERR_RST_MASK;
    logic sel;
    assign sel = wr_acc && (dec_grp == GIDX_W'(g));

    irq_group #(.DATA_W(DATA_W), .RST_MASK(RM)) i_grp (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .evt_i     (evt_a[g]),
      .stat_wr_i (sel && (dec_slot == SLOT_STAT)),
      .en_wr_i   (sel && (dec_slot == SLOT_EN)),
      .dis_wr_i  (sel && (dec_slot == SLOT_DIS)),
      .wdata_i   (bus_wdata_i),
      .stat_o    (stat_a[g]),
      .mask_o    (mask_a[g]),
      .pend_o    (pend_a[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (dec_hit) begin
      case (dec_slot)
        SLOT_STAT: bus_rdata_o = stat_a[dec_grp];
        SLOT_MASK: bus_rdata_o = mask_a[dec_grp];
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  always_comb irq_d = |pend_a;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7: the line is the registered OR of the group pending flags
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o == $past(|pend_a));

  // R9: an undecoded address reads zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    !dec_hit |-> (bus_rdata_o == '0));
endmodule

// File: tb/test_irq_regbank.sv
module test_irq_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_nrm, evt_err;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;

  item_t sb[$];
  event  mon_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regbank i_irq_regbank (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_nrm_i   (evt_nrm),
    .evt_err_i   (evt_err),
    .bus_valid_i (bus_valid),
    .bus_write_i (bus_write),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  // monitor: pops the expected item and compares it with the live output
  initial begin
    forever begin
      @(mon_ev);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb.pop_front();
        got = it.is_irq ? {31'b0, irq} : bus_rdata;
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic push(input logic [31:0] e, input bit is_i, input string t);
    item_t it;
    it.exp = e; it.is_irq = is_i; it.tag = t;
    #1;
    sb.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    push(e, 1'b0, t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    push({31'b0, e}, 1'b1, t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] n, input logic [31:0] e);
    @(negedge clk);
    evt_nrm = n; evt_err = e;
    @(negedge clk);
    evt_nrm = '0; evt_err = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_nrm = '0; evt_err = '0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_rd(12'h004, 32'h0000_0000, "R1 normal status");
    chk_rd(12'h008, 32'h07FF_FFFF, "R1 normal mask");
    chk_rd(12'h014, 32'h0000_0000, "R1 error status");
    chk_rd(12'h018, 32'hFFFF_FFFF, "R1 error mask");
    chk_irq(1'b0, "R1 irq low");

    // R7: bit 28 of the normal group is unmasked from reset
    pulse(32'h1000_0000, '0);
    chk_rd(12'h004, 32'h1000_0000, "R2 bit28 sticky");
    chk_irq(1'b1, "R7 irq on reset-unmasked bit");
    wr(12'h004, 32'h1000_0000);
    chk_rd(12'h004, 32'h0000_0000, "R3 clear bit28");
    chk_irq(1'b0, "R7 irq drops after clear");

    // R2 masked event
    pulse(32'h0000_0008, '0);
    chk_rd(12'h004, 32'h0000_0008, "R2 bit3 set");
    chk_irq(1'b0, "R7 masked source no irq");

    // R4 enable
    wr(12'h00C, 32'h0000_0008);
    chk_rd(12'h008, 32'h07FF_FFF7, "R4 enable clears mask bit");
    chk_rd(12'h00C, 32'h0000_0000, "R4 enable reads zero");
    chk_irq(1'b1, "R7 irq after unmask");

    // R6 direct mask writes ignored
    wr(12'h008, 32'h0000_0000);
    chk_rd(12'h008, 32'h07FF_FFF7, "R6 normal mask unchanged");
    wr(12'h018, 32'h0000_0000);
    chk_rd(12'h018, 32'hFFFF_FFFF, "R6 error mask unchanged");

    // R3 zero bits keep
    wr(12'h004, 32'h0000_0004);
    chk_rd(12'h004, 32'h0000_0008, "R3 written-zero bit kept");

    // R5 disable
    wr(12'h010, 32'h0000_0008);
    chk_rd(12'h008, 32'h07FF_FFFF, "R5 disable sets mask bit");
    chk_rd(12'h010, 32'h0000_0000, "R5 disable reads zero");
    chk_irq(1'b0, "R7 irq off after mask");
    wr(12'h004, 32'h0000_0008);
    chk_rd(12'h004, 32'h0000_0000, "R3 clear bit3");

    // error group
    wr(12'h01C, 32'h8000_0001);
    chk_rd(12'h018, 32'h7FFF_FFFE, "R4 error enable");
    pulse('0, 32'h8000_0000);
    chk_rd(12'h014, 32'h8000_0000, "R2 error bit31 set");
    chk_irq(1'b1, "R7 irq from error group");

    // R8 event and clear in the same cycle
    @(negedge clk);
    evt_err = 32'h0000_0001;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h014; bus_wdata = 32'h8000_0001;
    @(negedge clk);
    evt_err = '0; bus_valid = 1'b0; bus_write = 1'b0;
    chk_rd(12'h014, 32'h0000_0001, "R8 event beats clear");
    chk_irq(1'b1, "R7 irq held by surviving bit");

    wr(12'h020, 32'h0000_0001);
    chk_rd(12'h018, 32'h7FFF_FFFF, "R5 error disable");
    chk_rd(12'h020, 32'h0000_0000, "R5 error disable reads zero");
    chk_irq(1'b0, "R7 irq off, error masked");

    // R9 unmapped
    wr(12'h024, 32'hFFFF_FFFF);
    chk_rd(12'h024, 32'h0000_0000, "R9 unmapped reads zero");
    chk_rd(12'h000, 32'h0000_0000, "R9 below map reads zero");
    chk_rd(12'h014, 32'h0000_0001, "R9 error status untouched");
    chk_rd(12'h008, 32'h07FF_FFFF, "R9 normal mask untouched");
    wr(12'h014, 32'h0000_0001);
    chk_rd(12'h014, 32'h0000_0000, "R3 error clear");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule